// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a 32-bit synchronous SRAM with registered inputs and a registered read path. Every control, address and write-data input is captured on the rising clock edge. The array is updated or read on the edge that follows, and read data leaves through an output register. The address comes from an external burst sequencer, so each cycle presents one complete word address.

Writes are byte-granular. A global write control stores all four bytes. Without it, a byte-write enable qualifies four per-byte selects. The part is selected only when all three active-low chip enables are asserted. An active-low output enable gates a drive flag that stands in for tri-state pads. The first read after any deselected cycle, including the state after reset, is returned with the drive flag forced low. A sleep input freezes the array and silences the outputs, and it preserves the stored contents.

Top module: `sbsram_core`

## Requirements
- R1: While reset is asserted and directly after its release, drive_en is 0 and rdata is all zeros.
- R2: For a read whose inputs are captured at clock edge k, drive_en is 1 and rdata holds the addressed word after edge k+1, provided the output enable is low and the read is not masked.
- R3: With gw_n low on a selected cycle, all four bytes of the addressed word are written, whatever bwe_n and bsel_n hold.
- R4: With gw_n high and bwe_n low, byte i (bits 8i+7..8i) is written only when bsel_n[i] is low. The other bytes keep their old values.
- R5: A selected cycle that enables no byte, such as bwe_n high with every bsel_n low, is a read and leaves the array unchanged.
- R6: While oe_n is high, drive_en is 0 and rdata is all zeros, and this takes effect without waiting for a clock edge.
- R7: The first read after a deselected cycle (or after reset) has drive_en 0. A read that directly follows it drives normally.
- R8: If any of ce1_n, ce2_n, ce3_n is high at capture, the cycle writes nothing and produces no driven read data.
- R9: While sleep is high, drive_en is 0, and writes and reads captured with sleep high do nothing. Contents written before sleep can be read back unchanged after sleep.
- R10: A word written in one cycle is returned by a read of the same address issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | AW | Word address from the burst sequencer |
| wdata | input | 8*NB | Write data, byte i in bits 8i+7..8i |
| gw_n | input | 1 | Global write, active low, writes every byte |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NB | Per-byte selects, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2_n | input | 1 | Chip enable 2, active low |
| ce3_n | input | 1 | Chip enable 3, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | 8*NB | Read data, zero when not driven |
| drive_en | output | 1 | High when the data outputs would be driven |

## Verification
The hardest case to reach is the masked read. It needs a deselected cycle followed directly by a read, and then a second read whose data must appear without the mask. Sleep makes it harder, because sleep cycles must leave that deselect history alone. The bench inserts deselected write attempts, one for each chip enable, right before a back-to-back read sweep. It also places a sleep window between two selected reads, so the read after wake-up must drive normally.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Captured control bundle for one access cycle
  typedef struct packed {
    logic sel;     // all chip enables asserted
    logic sleep;   // sleep request at capture
    logic gw_n;    // global write
    logic bwe_n;   // byte-write enable
  } ctl_t;

endpackage

// File: rtl/sbsram_in_reg.sv
module sbsram_in_reg
  import sbsram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4,
  localparam int DW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          ce1_n,
  input  logic          ce2_n,
  input  logic          ce3_n,
  input  logic          sleep,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata,
  output logic [NB-1:0] q_bsel_n,
  output ctl_t          q_ctl
);

  ctl_t ctl_d;

  always_comb begin
    ctl_d.sel   = ~ce1_n & ~ce2_n & ~ce3_n;
    ctl_d.sleep = sleep;
    ctl_d.gw_n  = gw_n;
    ctl_d.bwe_n = bwe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr   <= '0;
      q_wdata  <= '0;
      q_bsel_n <= '1;
      q_ctl    <= '{sel: 1'b0, sleep: 1'b0, gw_n: 1'b1, bwe_n: 1'b1};
    end else begin
      q_addr   <= addr;
      q_wdata  <= wdata;
      q_bsel_n <= bsel_n;
      q_ctl    <= ctl_d;
    end
  end

endmodule

// File: rtl/sbsram_wr_mask.sv
module sbsram_wr_mask
  import sbsram_pkg::*;
#(
  parameter int NB = 4
) (
  input  ctl_t          q_ctl,
  input  logic [NB-1:0] q_bsel_n,
  output logic [NB-1:0] byte_we,
  output logic          rd_req
);

  logic active;

  assign active = q_ctl.sel & ~q_ctl.sleep;

  // Global write wins; otherwise byte enable qualifies each select
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_we[b] = active & (~q_ctl.gw_n | (~q_ctl.bwe_n & ~q_bsel_n[b]));
  end

  assign rd_req = active & ~(|byte_we);

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW = 10,
  parameter int NB = 4,
  localparam int DW    = 8 * NB,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_wdata,
  input  logic [NB-1:0] byte_we,
  input  logic          rd_req,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dout_d;

  // Storage: no reset, as a real macro would have none
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (byte_we[b]) begin
        mem[q_addr][b*8 +: 8] <= q_wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    dout_d = dout;
    if (rd_req) begin
      dout_d = mem[q_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else begin
      dout <= dout_d;
    end
  end

endmodule

// File: rtl/sbsram_out_ctl.sv
module sbsram_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic q_sel,
  input  logic q_sleep,
  input  logic oe_n,
  input  logic sleep,
  output logic drive_en
);

  logic ovld_q, ovld_d;
  logic omask_q, omask_d;
  logic idle_q, idle_d;   // last non-sleep cycle was deselected

  always_comb begin
    ovld_d  = rd_req;
    omask_d = rd_req & idle_q;
    idle_d  = idle_q;
    if (!q_sleep) begin
      idle_d = ~q_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovld_q  <= 1'b0;
      omask_q <= 1'b0;
      idle_q  <= 1'b1;
    end else begin
      ovld_q  <= ovld_d;
      omask_q <= omask_d;
      idle_q  <= idle_d;
    end
  end

  assign drive_en = ovld_q & ~omask_q & ~oe_n & ~sleep;

  // R7: a read captured right after a deselected cycle is never driven
  p_first_read_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && idle_q && !q_sleep) |=> !drive_en);

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4,
  localparam int DW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          ce1_n,
  input  logic          ce2_n,
  input  logic          ce3_n,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          drive_en
);

  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [NB-1:0] q_bsel_n;
  ctl_t          q_ctl;
  logic [NB-1:0] byte_we;
  logic          rd_req;
  logic [DW-1:0] dout;

  sbsram_in_reg #(.AW(AW), .NB(NB)) in_reg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .ce3_n    (ce3_n),
    .sleep    (sleep),
    .q_addr   (q_addr),
    .q_wdata  (q_wdata),
    .q_bsel_n (q_bsel_n),
    .q_ctl    (q_ctl)
  );

  sbsram_wr_mask #(.NB(NB)) wr_mask_i (
    .q_ctl    (q_ctl),
    .q_bsel_n (q_bsel_n),
    .byte_we  (byte_we),
    .rd_req   (rd_req)
  );

  sbsram_array #(.AW(AW), .NB(NB)) array_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_addr  (q_addr),
    .q_wdata (q_wdata),
    .byte_we (byte_we),
    .rd_req  (rd_req),
    .dout    (dout)
  );

  sbsram_out_ctl out_ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .q_sel    (q_ctl.sel),
    .q_sleep  (q_ctl.sleep),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .drive_en (drive_en)
  );

  assign rdata = drive_en ? dout : '0;

  // R8: a deselected capture enables no byte and requests no read
  p_desel_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !q_ctl.sel |-> (byte_we == '0 && !rd_req));

  // R3: global write on an active cycle covers every byte
  p_global_all_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctl.sel && !q_ctl.sleep && !q_ctl.gw_n) |-> (&byte_we));

  // R9: sleeping captures touch nothing
  p_sleep_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_ctl.sleep |-> (byte_we == '0 && !rd_req));

  // R2: driven data always comes from a read captured one edge earlier
  p_drive_from_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> $past(rd_req));

  // R6: output enable high keeps the bus quiet
  p_oe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!drive_en && rdata == '0));

endmodule

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;

  localparam int AW = 4;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          gw_n, bwe_n;
  logic [NB-1:0] bsel_n;
  logic          ce1_n, ce2_n, ce3_n;
  logic          oe_n, sleep;
  logic [DW-1:0] rdata;
  logic          drive_en;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] ref_mem [N];

  always #10 clk = ~clk;   // 50 MHz

  sbsram_core #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3_n(ce3_n),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .drive_en(drive_en)
  );

  function automatic logic [DW-1:0] wpat(input int a);
    return 32'h5A3C_9600 ^ (a * 32'h0101_0103);
  endfunction

  // One access: inputs set at a falling edge, held over one rising edge
  task automatic op(input logic [2:0] cen, input logic g, input logic bw,
                    input logic [3:0] bs, input int a, input logic [DW-1:0] d,
                    input logic slp);
    ce1_n = cen[0]; ce2_n = cen[1]; ce3_n = cen[2];
    gw_n = g; bwe_n = bw; bsel_n = bs; addr = a[AW-1:0]; wdata = d; sleep = slp;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic slp);
    op(3'b000, 1'b1, 1'b1, 4'hF, a, 32'h0, slp);
  endtask

  task automatic expect_rd(input string req, input logic ed, input logic [DW-1:0] edat);
    n_chk++;
    if (drive_en !== ed || rdata !== edat) begin
      n_err++;
      $display("FAIL %s: drive_en=%b rdata=%h expected drive_en=%b rdata=%h",
               req, drive_en, rdata, ed, edat);
    end
  endtask

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    ce1_n = 1'b1; ce2_n = 1'b1; ce3_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    expect_rd("R1 in reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_rd("R1 after release", 1'b0, 32'h0);

    // R3: global write everywhere, byte controls scrambled
    for (int a = 0; a < N; a++) begin
      op(3'b000, 1'b0, a[0], a[3:0] ^ 4'h5, a, wpat(a), 1'b0);
      ref_mem[a] = wpat(a);
    end
    expect_rd("R3 write cycle undriven", 1'b0, 32'h0);

    // R4: every select pattern under byte-write enable
    for (int a = 0; a < N; a++) begin
      op(3'b000, 1'b1, 1'b0, a[3:0], a, ~wpat(a), 1'b0);
      for (int b = 0; b < NB; b++)
        if (!a[b]) ref_mem[a][b*8 +: 8] = ~wpat(a) >> (b*8);
    end

    // R8: one chip enable high at a time, global write attempted
    for (int i = 0; i < 3; i++)
      op(3'b001 << i, 1'b0, 1'b0, 4'h0, i, 32'hDEAD_BEEF, 1'b0);
    expect_rd("R8 deselected undriven", 1'b0, 32'h0);

    // R7 then R2/R3/R4/R8: back-to-back read sweep
    rd(0, 1'b0);
    for (int a = 0; a < N; a++) begin
      rd(a, 1'b0);
      if (a == 0) expect_rd("R7 first read masked", 1'b0, 32'h0);
      else        expect_rd("R2 read sweep", 1'b1, ref_mem[a-1]);
      if (a == 8) begin
        oe_n = 1'b1; #1;
        expect_rd("R6 oe high", 1'b0, 32'h0);
        oe_n = 1'b0; #1;
        expect_rd("R6 oe restored", 1'b1, ref_mem[a-1]);
      end
    end

    // R5: byte enable off with every select low is a plain read
    op(3'b000, 1'b1, 1'b1, 4'h0, 5, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R2 last sweep word", 1'b1, ref_mem[N-1]);
    rd(6, 1'b0);
    expect_rd("R5 no-byte cycle reads", 1'b1, ref_mem[5]);
    rd(6, 1'b0);
    expect_rd("R5 neighbour intact", 1'b1, ref_mem[6]);

    // R10: write then immediate read, full word and single byte
    op(3'b000, 1'b0, 1'b1, 4'hF, 7, 32'h1234_5678, 1'b0);
    ref_mem[7] = 32'h1234_5678;
    rd(7, 1'b0);
    expect_rd("R10 write cycle undriven", 1'b0, 32'h0);
    rd(8, 1'b0);
    expect_rd("R10 full word back", 1'b1, ref_mem[7]);
    op(3'b000, 1'b1, 1'b0, 4'b1110, 8, 32'hCAFE_F00D, 1'b0);
    ref_mem[8][7:0] = 8'h0D;
    rd(8, 1'b0);
    rd(9, 1'b0);
    expect_rd("R10 byte write back", 1'b1, ref_mem[8]);

    // R9: sleep window
    op(3'b000, 1'b0, 1'b0, 4'h0, 9, 32'hFFFF_0000, 1'b1);
    expect_rd("R9 sleep gates drive", 1'b0, 32'h0);
    rd(9, 1'b1);
    expect_rd("R9 sleeping write inert", 1'b0, 32'h0);
    rd(9, 1'b0);
    expect_rd("R9 sleeping read inert", 1'b0, 32'h0);
    rd(10, 1'b0);
    expect_rd("R9 contents kept", 1'b1, ref_mem[9]);
    rd(10, 1'b0);
    expect_rd("R9 follow-on read", 1'b1, ref_mem[10]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule